// File: doc/BRIEF.md
# Sequenced One's-Complement Accumulator

This unit keeps a signed accumulator in one's-complement form and adds or subtracts an operand into it, one phase per clock. An addition runs in two phases. The half-add phase complements each accumulator bit whose operand bit is set. The carry phase then resolves every carry at once from the operand and the half-added accumulator, and a carry that leaves the top bit re-enters at the bottom.

Subtraction comes in two forms. The first complements the captured operand and then adds it. The second complements the accumulator, adds, and complements the accumulator again. The operand is captured when a start is accepted, so the source may move on while the sequence runs.

The accumulator clears to zero at reset. A value is loaded by adding it to a zero accumulator.

Top module: `ones_acc_unit`

## Requirements
- R1: After reset the accumulator reads 0, and busy and done are both low.
- R2: In the half-add phase, each accumulator bit whose captured operand bit is 1 is inverted and the other bits are kept. The result is visible at `acc` one clock after the phase begins.
- R3: In the carry phase, a carry starts at a bit where the operand is 1 and the half-added accumulator is 0. A carry passes through a bit where the half-added accumulator is 1. Every bit that receives a carry is inverted. For a zero-extended word, operand 001 with accumulator 010 gives 011 then 011; with 001 it gives 000 then 010; with 011 it gives 010 then 100.
- R4: A carry out of the most significant bit re-enters at bit 0 (end-around). For example, 0x80 plus 0x81 gives 0x02, and adding 0xFF (negative zero) leaves 0x7F unchanged.
- R5: `op_sel` 2'b00 selects addition: half-add, then carry (2 phases). The code 2'b11 behaves exactly like 2'b00.
- R6: `op_sel` 2'b01 subtracts in 3 phases: invert the captured operand (accumulator unchanged), half-add, then carry. The result is the accumulator plus the inverted operand with end-around carry.
- R7: `op_sel` 2'b10 subtracts in 4 phases: invert the accumulator, half-add, carry, then invert the accumulator again.
- R8: A start is accepted on a clock edge where busy is low. Busy is high from the next cycle through the cycle of the last phase. Done is high for exactly one cycle, the cycle after the last phase, and busy is low in that cycle.
- R9: The operand and the operation are captured when a start is accepted. Changing the `operand` port while busy does not change the result.
- R10: A start raised while busy is ignored. The sequence keeps its length and its result, and it does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin an operation |
| op_sel | input | 2 | 00/11 add, 01 subtract by operand inversion, 10 subtract by accumulator inversion |
| operand | input | W | Value to add or subtract |
| acc | output | W | Accumulator |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the final phase |

## Verification
The bench reads `acc` after each phase as well as at the end. A half-add that also applied carries, or a subtract mode that ran its phases in the wrong order, shows up at the intermediate value. It checks carries that run across several bits and carries that leave the top bit. A missing end-around carry would give 0x01 instead of 0x02, and adding negative zero would then corrupt the accumulator. It moves the operand port and raises start again in the middle of a sequence. A design that re-sampled the operand or restarted would give a wrong result or raise done late. It counts the phases of each mode, and a wrong sequence length moves the done pulse.

// File: rtl/ones_acc_pkg.sv
package ones_acc_pkg;

  typedef enum logic [1:0] {
    MODE_ADD    = 2'b00,
    MODE_SUB_OP = 2'b01,
    MODE_SUB_AC = 2'b10,
    MODE_ADD_ALT = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_INV_OPND  = 3'd1,
    PH_INV_PRE   = 3'd2,
    PH_HALF      = 3'd3,
    PH_CARRY     = 3'd4,
    PH_INV_POST  = 3'd5
  } phase_e;

endpackage

// File: rtl/ones_acc_rst_sync.sv
module ones_acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/ones_acc_carry.sv
module ones_acc_carry #(
  parameter int W = 8
) (
  input  logic [W-1:0] half_val,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] sum
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W-1:0] cin_vec;
  logic         wrap;

  assign gen  = opnd & ~half_val;
  assign prop = half_val;

  // Carry into each bit: the first pass finds the carry out of the top bit,
  // the second pass feeds it back into bit 0.
  always_comb begin
    logic c;
    c = 1'b0;
    for (int i = 0; i < W; i++) begin
      c = gen[i] | (prop[i] & c);
    end
    wrap = c;
    c = wrap;
    for (int i = 0; i < W; i++) begin
      cin_vec[i] = c;
      c = gen[i] | (prop[i] & c);
    end
  end

  assign sum = half_val ^ cin_vec;
endmodule

// File: rtl/ones_acc_seq.sv
module ones_acc_seq
  import ones_acc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_s,
  input  logic   start,
  input  logic [1:0] op_sel,
  output phase_e phase,
  output logic   accept,
  output logic   done
);
  phase_e phase_q, phase_d;
  mode_e  mode_q, mode_d;
  logic   done_d;

  assign accept = start && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    mode_d  = mode_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        mode_d = mode_e'(op_sel);
        unique case (mode_e'(op_sel))
          MODE_SUB_OP: phase_d = PH_INV_OPND;
          MODE_SUB_AC: phase_d = PH_INV_PRE;
          default:     phase_d = PH_HALF;
        endcase
      end
      PH_INV_OPND: phase_d = PH_HALF;
      PH_INV_PRE:  phase_d = PH_HALF;
      PH_HALF:     phase_d = PH_CARRY;
      PH_CARRY: begin
        if (mode_q == MODE_SUB_AC) phase_d = PH_INV_POST;
        else begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      PH_INV_POST: begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      phase_q <= PH_IDLE;
      mode_q  <= MODE_ADD;
      done    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      mode_q  <= mode_d;
      done    <= done_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/ones_acc_unit.sv
module ones_acc_unit
  import ones_acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc,
  output logic         busy,
  output logic         done
);
  logic         rst_s;
  phase_e       phase;
  logic         accept;
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] opnd_q, opnd_d;
  logic         acc_en, opnd_en;
  logic [W-1:0] carry_sum;

  ones_acc_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  ones_acc_seq u_seq (
    .clk    (clk),
    .rst_s  (rst_s),
    .start  (start),
    .op_sel (op_sel),
    .phase  (phase),
    .accept (accept),
    .done   (done)
  );

  ones_acc_carry #(.W(W)) u_carry (
    .half_val (acc_q),
    .opnd     (opnd_q),
    .sum      (carry_sum)
  );

  always_comb begin
    opnd_en = accept || (phase == PH_INV_OPND);
    opnd_d  = accept ? operand : ~opnd_q;
    acc_en  = 1'b0;
    acc_d   = acc_q;
    unique case (phase)
      PH_HALF: begin
        acc_en = 1'b1;
        acc_d  = acc_q ^ opnd_q;
      end
      PH_CARRY: begin
        acc_en = 1'b1;
        acc_d  = carry_sum;
      end
      PH_INV_PRE, PH_INV_POST: begin
        acc_en = 1'b1;
        acc_d  = ~acc_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      acc_q  <= '0;
      opnd_q <= '0;
    end else begin
      if (acc_en)  acc_q  <= acc_d;
      if (opnd_en) opnd_q <= opnd_d;
    end
  end

  assign acc  = acc_q;
  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/ones_acc_chk.sv
module ones_acc_chk
  import ones_acc_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_s,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] acc,
  input logic [W-1:0] opnd_q,
  input phase_e       phase
);
  function automatic logic [W-1:0] oc_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W-1:0] + {{(W-1){1'b0}}, s[W]};
  endfunction

  // R8: done never overlaps busy, and lasts one cycle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_s) done |-> !busy);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_s) done |=> !done);
  a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_s) $rose(busy) |-> $past(start));
  // R2: half-add inverts the bits selected by the operand
  a_r2_half_step: assert property (@(posedge clk) disable iff (!rst_s)
    (phase == PH_HALF) |=> (acc == ($past(acc) ^ $past(opnd_q))));
  // R4: carry phase completes an end-around one's-complement sum
  a_r4_carry_sum: assert property (@(posedge clk) disable iff (!rst_s)
    (phase == PH_CARRY) |=> (acc == oc_sum($past(acc) ^ $past(opnd_q), $past(opnd_q))));
  // R7: closing inversion of the accumulator
  a_r7_post_invert: assert property (@(posedge clk) disable iff (!rst_s)
    (phase == PH_INV_POST) |=> (acc == ~$past(acc)));
  // R10: operand is not recaptured while busy
  a_r10_no_recapture: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && phase != PH_INV_OPND) |=> $stable(opnd_q));
endmodule

bind ones_acc_unit ones_acc_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_s  (rst_s),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .acc    (acc),
  .opnd_q (opnd_q),
  .phase  (phase)
);

// File: tb/ones_acc_unit_test.sv
module ones_acc_unit_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   op_sel;
  logic [W-1:0] operand;
  logic [W-1:0] acc;
  logic         busy;
  logic         done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  ones_acc_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .operand(operand), .acc(acc), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s[W]) return s[W-1:0] + 1'b1;
    return s[W-1:0];
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Launch one operation and follow it phase by phase.
  task automatic run_op(input logic [1:0] op, input logic [W-1:0] val, input int mid_idx,
                        input logic [W-1:0] exp_mid, input logic [W-1:0] exp_fin, input string tag);
    int n;
    n = (op == 2'b01) ? 3 : (op == 2'b10) ? 4 : 2;
    @(negedge clk);
    start = 1'b1; op_sel = op; operand = val;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; operand = ~val; op_sel = 2'b10;  // R9 port moves while busy
    check({31'd0, busy}, 32'd1, {tag, " R8 busy after start"});
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == mid_idx) check(acc, exp_mid, {tag, " intermediate"});
      if (k < n) check({30'd0, busy, done}, 32'd2, {tag, " R8 busy during phases"});
      else       check({30'd0, busy, done}, 32'd1, {tag, " R8 done pulse"});
    end
    check(acc, exp_fin, {tag, " result R9"});
    @(posedge clk);
    @(negedge clk);
    check({31'd0, done}, 32'd0, {tag, " R8 done one cycle"});
  endtask

  task automatic set_acc(input logic [W-1:0] v);
    logic [W-1:0] cur;
    cur = acc;
    run_op(2'b01, cur, 0, '0, {W{1'b1}}, "R6 clear to negative zero");
    run_op(2'b00, v, 2, v, v, "R4 load");
  endtask

  task automatic t_reset;
    check(acc, 0, "R1 acc reset");
    check({31'd0, busy}, 0, "R1 busy reset");
    check({31'd0, done}, 0, "R1 done reset");
  endtask

  task automatic t_examples;
    run_op(2'b00, 8'h02, 1, 8'h02, 8'h02, "R5 load from zero");
    run_op(2'b00, 8'h01, 1, 8'h03, 8'h03, "R3 ex 001+010 R2");
    set_acc(8'h01);
    run_op(2'b00, 8'h01, 1, 8'h00, 8'h02, "R3 ex 001+001 R2");
    set_acc(8'h03);
    run_op(2'b00, 8'h01, 1, 8'h02, 8'h04, "R3 ex 001+011 R2");
    set_acc(8'h55);
    run_op(2'b00, 8'h0F, 1, 8'h5A, 8'h64, "R3 long carry run");
  endtask

  task automatic t_wrap;
    set_acc(8'h80);
    run_op(2'b00, 8'h81, 1, 8'h01, 8'h02, "R4 end-around");
    set_acc(8'h7F);
    run_op(2'b00, 8'hFF, 1, 8'h80, 8'h7F, "R4 add negative zero");
  endtask

  task automatic t_alt_add;
    set_acc(8'h05);
    run_op(2'b11, 8'h0A, 1, 8'h0F, 8'h0F, "R5 code 11 adds");
  endtask

  task automatic t_sub_opnd;
    set_acc(8'h20);
    run_op(2'b01, 8'h05, 1, 8'h20, ref_add(8'h20, ~8'h05), "R6 acc held in first phase");
    check(acc, 8'h1B, "R6 32-5");
    set_acc(8'h20);
    run_op(2'b01, 8'h05, 2, 8'h20 ^ 8'hFA, 8'h1B, "R6 half-add of inverted operand");
    set_acc(8'h05);
    run_op(2'b01, 8'h20, 3, 8'hE4, 8'hE4, "R6 negative result");
  endtask

  task automatic t_sub_acc;
    set_acc(8'h20);
    run_op(2'b10, 8'h05, 1, 8'hDF, 8'h1B, "R7 pre-invert");
    set_acc(8'h20);
    run_op(2'b10, 8'h05, 3, 8'hE4, 8'h1B, "R7 sum before post-invert");
  endtask

  task automatic t_start_busy;
    set_acc(8'h10);
    @(negedge clk);
    start = 1'b1; op_sel = 2'b00; operand = 8'h03;
    @(posedge clk);
    @(negedge clk);
    op_sel = 2'b10; operand = 8'h40;  // start held high while busy
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check({30'd0, busy, done}, 32'd2, "R10 still in first sequence");
    @(posedge clk);
    @(negedge clk);
    check({30'd0, busy, done}, 32'd1, "R10 done at normal length");
    check(acc, 8'h13, "R10 result of first request");
    @(posedge clk);
    @(negedge clk);
    check({31'd0, busy}, 32'd0, "R10 no restart");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op_sel = 2'b00; operand = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    t_examples;
    t_wrap;
    t_alt_add;
    t_sub_opnd;
    t_sub_acc;
    t_start_busy;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule